// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer for a host on a simple register bus. It counts upward on a slow tick input, which is typically a 32 kHz enable pulse in the fast clock domain. An optional power-of-two prescaler sits in front of the counter. If the counter wraps from all ones to zero while the watchdog is armed, the block raises a one-clock reset request and reloads the counter from the load register.

Software arms and disarms the watchdog only through ordered pairs of key words written to a key register. It services the watchdog by writing a trigger word that differs from the previous one. Every register write is posted. The written word is held in a slot for a fixed number of clock cycles, which models the crossing into the slow domain. While the word is held, a pending flag for that register reads 1. The prescaler configuration and the load value are frozen while the watchdog is armed.

Register word addresses: 0 revision (read-only), 1 prescaler control, 2 pending status (read-only), 3 counter (read-only), 4 load, 5 trigger, 6 key.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the block is disarmed. The counter, load, control and pending status all read 0, and `rst_req_o` is low. Address 0 returns the revision code (parameter `REV_CODE`, default 8'h2A) in bits 7:0.
- R2: Writing 32'h0000BBBB to the key register and then 32'h00004444 as the next key write arms the watchdog. Once armed, the counter advances on ticks.
- R3: Writing 32'h0000AAAA to the key register and then 32'h00005555 as the next key write disarms the watchdog. While disarmed, ticks leave the counter unchanged.
- R4: Suppose the key write after a first key word is not the matching second word. The sequence then returns to idle and the armed state is unchanged. A later correct second word alone does nothing.
- R5: Pending status bit 0 belongs to control, bit 2 to load, bit 3 to trigger and bit 4 to key. A bit reads 1 for exactly `PEND_CYC` (default 4) cycles after the write edge. The write takes effect at the edge where the bit clears.
- R6: Control and load writes that take effect while the watchdog is armed are discarded.
- R7: A trigger write whose value differs from the last accepted trigger value reloads the counter from the load register. A trigger write equal to the last value does nothing. The last trigger value is 0 after reset.
- R8: The control register holds the prescaler enable in bit 5 and the prescaler exponent P in bits 4:2. With the enable bit clear, the counter advances once per tick. With it set, the counter advances once per 2^P ticks.
- R9: When an armed counter wraps from all ones, `rst_req_o` is high for exactly one cycle and the counter reloads from the load register.
- R10: Control reads back with only bits 5:2 kept. Load reads back as written.
- R11: A write to a register whose pending bit is already set is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Slow tick enable, one cycle per tick |
| addr_i | input | 3 | Register word address |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | DATA_W | Read data for `addr_i` (combinational) |
| rst_req_o | output | 1 | One-cycle reset request on an armed wrap |

## Verification
The main counting path is run from a table that covers these cases:
- Prescaler off.
- Prescaler on with exponent 0. This must match the off case.
- Exponents 1, 2 and 3, with tick counts that are not multiples of the divisor. These separate a correct divider from an off-by-one divider.

Further directed cases cover the rest:
- Key sequences: a correct pair, a pair broken by a foreign word, and a lone second word. These separate a two-step lock from a single-word one.
- Service writes: equal trigger values against changed ones.
- Wrap: a load near all ones, so the request pulse and the reload can be seen.
- Posted writes: a second write made while the first is pending.

// File: rtl/wdt_key_pkg.sv
package wdt_key_pkg;
    localparam int ADDR_W = 3;
    localparam int PTV_W  = 3;
    localparam int N_SLOT = 4;

    localparam logic [ADDR_W-1:0] A_REV   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_PEND  = 3'd2;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd3;
    localparam logic [ADDR_W-1:0] A_LOAD  = 3'd4;
    localparam logic [ADDR_W-1:0] A_TRIG  = 3'd5;
    localparam logic [ADDR_W-1:0] A_KEY   = 3'd6;

    localparam int S_CTRL = 0;
    localparam int S_LOAD = 1;
    localparam int S_TRIG = 2;
    localparam int S_KEY  = 3;

    localparam logic [15:0] KEY_ON_A  = 16'hBBBB;
    localparam logic [15:0] KEY_ON_B  = 16'h4444;
    localparam logic [15:0] KEY_OFF_A = 16'hAAAA;
    localparam logic [15:0] KEY_OFF_B = 16'h5555;

    typedef enum logic [1:0] {K_IDLE, K_ARM_ON, K_ARM_OFF} key_state_e;

    typedef struct packed {
        logic             pre_en;
        logic [PTV_W-1:0] ptv;
    } presc_cfg_t;

    function automatic int pend_bit(input int slot);
        case (slot)
            S_CTRL:  return 0;
            S_LOAD:  return 2;
            S_TRIG:  return 3;
            default: return 4;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] slot_addr(input int slot);
        case (slot)
            S_CTRL:  return A_CTRL;
            S_LOAD:  return A_LOAD;
            S_TRIG:  return A_TRIG;
            default: return A_KEY;
        endcase
    endfunction
endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
    parameter int DATA_W   = 32,
    parameter int PEND_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              pend_o,
    output logic              apply_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int CW = $clog2(PEND_CYC + 1);

    logic              pend_q;
    logic [CW-1:0]     cnt_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
            data_q <= '0;
        end else if (!pend_q && wr_i) begin
            pend_q <= 1'b1;
            cnt_q  <= CW'(PEND_CYC - 1);
            data_q <= wdata_i;
        end else if (pend_q) begin
            if (cnt_q == '0) pend_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign pend_o  = pend_q;
    assign apply_o = pend_q && (cnt_q == '0);
    assign data_o  = data_q;

    // R5: pending only ever starts from a bus write
    p_pend_start_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(wr_i));
    // R11: a write arriving while pending leaves the held word alone
    p_drop_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (pend_q && wr_i) |=> $stable(data_q));
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_key_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              apply_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              run_o
);
    key_state_e st_q;
    logic       run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= K_IDLE;
            run_q <= 1'b0;
        end else if (apply_i) begin
            st_q <= K_IDLE;
            case (st_q)
                K_ARM_ON:  if (data_i == DATA_W'(KEY_ON_B))  run_q <= 1'b1;
                K_ARM_OFF: if (data_i == DATA_W'(KEY_OFF_B)) run_q <= 1'b0;
                default: begin
                    if (data_i == DATA_W'(KEY_ON_A))       st_q <= K_ARM_ON;
                    else if (data_i == DATA_W'(KEY_OFF_A)) st_q <= K_ARM_OFF;
                end
            endcase
        end
    end

    assign run_o = run_q;

    // R2: arming needs the first enable word to have been seen
    p_arm_order_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> $past(st_q == K_ARM_ON));
    // R3: disarming needs the first disable word to have been seen
    p_disarm_order_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(run_q) |-> $past(st_q == K_ARM_OFF));
endmodule

// File: rtl/wdt_count.sv
module wdt_count
    import wdt_key_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              tick_i,
    input  presc_cfg_t        cfg_i,
    input  logic              div_clr_i,
    input  logic              reload_i,
    input  logic [DATA_W-1:0] load_i,
    output logic [DATA_W-1:0] count_o,
    output logic              req_o
);
    localparam int DIV_W = (1 << PTV_W) - 1;

    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] count_q;
    logic              req_q;
    logic              step;

    always_comb begin
        step = 1'b0;
        if (run_i && tick_i) begin
            if (!cfg_i.pre_en) step = 1'b1;
            else step = (div_q == ((DIV_W'(1) << cfg_i.ptv) - DIV_W'(1)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i || div_clr_i) begin
            div_q <= '0;
        end else if (tick_i && cfg_i.pre_en) begin
            div_q <= step ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            req_q   <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (reload_i) begin
                count_q <= load_i;
            end else if (step) begin
                if (&count_q) begin
                    count_q <= load_i;
                    req_q   <= 1'b1;
                end else begin
                    count_q <= count_q + 1'b1;
                end
            end
        end
    end

    assign count_o = count_q;
    assign req_o   = req_q;

    // R9: request lasts a single cycle
    p_req_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        req_q |=> !req_q);
    // R9: request only from an armed counter
    p_req_armed_r9: assert property (@(posedge clk) disable iff (rst)
        req_q |-> $past(run_i));
    // R3: a disarmed counter moves only on reload
    p_hold_disarmed_r3: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !reload_i) |=> $stable(count_q));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_key_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int          PEND_CYC = 4,
    parameter logic [7:0]  REV_CODE = 8'h2A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rst_req_o
);
    localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(32'h0000_003C);

    logic [N_SLOT-1:0] pend;
    logic [N_SLOT-1:0] apply;
    logic [DATA_W-1:0] sdata [N_SLOT];

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        wdt_post_slot #(.DATA_W(DATA_W), .PEND_CYC(PEND_CYC)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_i    (we_i && (addr_i == slot_addr(g))),
            .wdata_i (wdata_i),
            .pend_o  (pend[g]),
            .apply_o (apply[g]),
            .data_o  (sdata[g])
        );
    end

    logic              run;
    logic [DATA_W-1:0] ctrl_q, load_q, trig_q, count;
    logic              reload, div_clr;
    presc_cfg_t        cfg;
    logic [DATA_W-1:0] pend_word;

    wdt_keyseq #(.DATA_W(DATA_W)) u_key (
        .clk     (clk),
        .rst     (rst),
        .apply_i (apply[S_KEY]),
        .data_i  (sdata[S_KEY]),
        .run_o   (run)
    );

    assign reload  = apply[S_TRIG] && (sdata[S_TRIG] != trig_q);
    assign div_clr = apply[S_CTRL] && !run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            load_q <= '0;
            trig_q <= '0;
        end else begin
            if (apply[S_CTRL] && !run) ctrl_q <= sdata[S_CTRL] & CTRL_MASK;
            if (apply[S_LOAD] && !run) load_q <= sdata[S_LOAD];
            if (reload)                trig_q <= sdata[S_TRIG];
        end
    end

    assign cfg.pre_en = ctrl_q[5];
    assign cfg.ptv    = ctrl_q[4:2];

    logic unused_ctrl;
    assign unused_ctrl = ^{ctrl_q[DATA_W-1:6], ctrl_q[1:0]};

    wdt_count #(.DATA_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .run_i     (run),
        .tick_i    (tick_i),
        .cfg_i     (cfg),
        .div_clr_i (div_clr),
        .reload_i  (reload),
        .load_i    (load_q),
        .count_o   (count),
        .req_o     (rst_req_o)
    );

    always_comb begin
        pend_word = '0;
        for (int i = 0; i < N_SLOT; i++) pend_word[pend_bit(i)] = pend[i];
    end

    always_comb begin
        case (addr_i)
            A_REV:   rdata_o = DATA_W'(REV_CODE);
            A_CTRL:  rdata_o = ctrl_q;
            A_PEND:  rdata_o = pend_word;
            A_COUNT: rdata_o = count;
            A_LOAD:  rdata_o = load_q;
            A_TRIG:  rdata_o = trig_q;
            default: rdata_o = '0;
        endcase
    end

    // R6: configuration is frozen while armed
    p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        run |=> ($stable(load_q) && $stable(ctrl_q)));
    // R7: the last trigger value changes only through a differing trigger
    p_trig_change_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(trig_q) |-> $past(apply[S_TRIG]));
endmodule

// File: tb/wdt_keyed_tb.sv
`timescale 1ns/1ps
module wdt_keyed_tb_top;
    localparam int PEND = 4;
    localparam int DW   = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic [2:0]    addr = 3'd0;
    logic [DW-1:0] wdata = '0;
    logic          we = 1'b0;
    logic [DW-1:0] rdata;
    logic          rst_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [DW-1:0] tv = 32'h0000_1234;

    always #10 clk = ~clk;

    wdt_keyed #(.DATA_W(DW), .PEND_CYC(PEND), .REV_CODE(8'h2A)) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick), .addr_i(addr),
        .wdata_i(wdata), .we_i(we), .rdata_o(rdata), .rst_req_o(rst_req)
    );

    // {pre_en, ptv[2:0], ticks[7:0], expected[7:0]}
    localparam logic [19:0] VEC [5] = '{
        {1'b0, 3'd0, 8'd10, 8'd10},
        {1'b1, 3'd0, 8'd7,  8'd7},
        {1'b1, 3'd1, 8'd11, 8'd5},
        {1'b1, 3'd2, 8'd10, 8'd2},
        {1'b1, 3'd3, 8'd23, 8'd2}
    };

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
        repeat (PEND) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic service();
        tv = ~tv; wr(3'd5, tv);
    endtask
    task automatic arm();
        wr(3'd6, 32'h0000_BBBB); wr(3'd6, 32'h0000_4444);
    endtask
    task automatic disarm();
        wr(3'd6, 32'h0000_AAAA); wr(3'd6, 32'h0000_5555);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v, c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); check(v & 32'hFF, 32'h2A, "R1 revision");
        rd(3'd2, v); check(v, 0, "R1 pending");
        rd(3'd3, v); check(v, 0, "R1 count");
        rd(3'd4, v); check(v, 0, "R1 load");
        rd(3'd1, v); check(v, 0, "R1 ctrl");
        check({31'd0, rst_req}, 0, "R1 rst_req");

        // R10 readback
        wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); check(v, 32'h3C, "R10 ctrl mask");
        wr(3'd4, 32'h1234_5678); rd(3'd4, v); check(v, 32'h1234_5678, "R10 load");
        wr(3'd1, 0);

        // R5 pending bit positions
        for (int s = 0; s < 4; s++) begin
            logic [2:0] a;
            logic [DW-1:0] e;
            a = (s == 0) ? 3'd1 : (s == 1) ? 3'd4 : (s == 2) ? 3'd5 : 3'd6;
            e = (s == 0) ? 32'h01 : (s == 1) ? 32'h04 : (s == 2) ? 32'h08 : 32'h10;
            @(negedge clk); addr = a; wdata = (s == 2) ? tv : 0; we = 1'b1;
            @(negedge clk); we = 1'b0; rd(3'd2, v); check(v, e, "R5 pending bit");
            repeat (PEND) @(negedge clk);
        end
        wr(3'd4, 0);

        // R5 duration and R11 drop
        @(negedge clk); addr = 3'd4; wdata = 32'h0000_00A0; we = 1'b1;
        @(negedge clk); rd(3'd2, v); check(v, 32'h04, "R5 pending cycle 1");
        addr = 3'd4; wdata = 32'h0000_00B0; we = 1'b1;
        @(negedge clk); we = 1'b0; rd(3'd2, v); check(v, 32'h04, "R5 pending cycle 2");
        @(negedge clk);
        @(negedge clk); rd(3'd2, v); check(v, 32'h04, "R5 pending last cycle");
        @(negedge clk); rd(3'd2, v); check(v, 32'h00, "R5 pending cleared");
        rd(3'd4, v); check(v, 32'h0000_00A0, "R11 second write dropped");

        // R8 / R2 prescaler table
        for (int k = 0; k < 5; k++) begin
            logic [19:0] e;
            e = VEC[k];
            disarm();
            wr(3'd1, {26'd0, e[19], e[18:16], 2'b00});
            wr(3'd4, 0);
            service();
            arm();
            pulse(int'(e[15:8]));
            rd(3'd3, v); check(v, {24'd0, e[7:0]}, "R8 R2 prescaled count");
        end

        // R3 disarm stops counting
        rd(3'd3, c0);
        disarm(); pulse(5); rd(3'd3, v); check(v, c0, "R3 disarmed hold");

        // R4 broken sequences
        wr(3'd1, 0);
        wr(3'd6, 32'h0000_BBBB); wr(3'd6, 32'h0000_1234); wr(3'd6, 32'h0000_4444);
        pulse(3); rd(3'd3, v); check(v, c0, "R4 broken arm ignored");
        arm(); pulse(2); rd(3'd3, v); check(v, c0 + 2, "R4 armed after correct pair");
        wr(3'd6, 32'h0000_AAAA); wr(3'd6, 32'h0000_4444); wr(3'd6, 32'h0000_5555);
        pulse(2); rd(3'd3, v); check(v, c0 + 4, "R4 broken disarm ignored");

        // R6 config frozen while armed
        wr(3'd4, 32'h0000_0100); wr(3'd1, 32'h0000_0024);
        rd(3'd4, v); check(v, 0, "R6 load frozen");
        rd(3'd1, v); check(v, 0, "R6 ctrl frozen");

        // R7 service with equal and changed values
        rd(3'd3, c0);
        wr(3'd5, tv); rd(3'd3, v); check(v, c0, "R7 equal trigger no reload");
        service(); rd(3'd3, v); check(v, 0, "R7 changed trigger reloads");

        // R9 wrap
        disarm();
        wr(3'd4, 32'hFFFF_FFFD);
        service();
        arm();
        pulse(2);
        rd(3'd3, v); check(v, 32'hFFFF_FFFF, "R9 at all ones");
        check({31'd0, rst_req}, 0, "R9 no request before wrap");
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0; check({31'd0, rst_req}, 1, "R9 request high");
        @(negedge clk); check({31'd0, rst_req}, 0, "R9 request one cycle");
        rd(3'd3, v); check(v, 32'hFFFF_FFFD, "R9 reload on wrap");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule